// File: doc/BRIEF.md
# Interrupt Source Controller

This block holds the source-side state for a configurable set of interrupt inputs. Each input is built as one of two kinds. A level source follows a wire. A message source reacts to a one-cycle trigger. A parameter bitmap fixes the kind of each source, so a reset never changes it. For each source the block stores a destination server, an 8-bit priority and an 8-bit saved priority. The priority value 0xFF means the source is masked. The block also keeps the status flags that let a delivery be retried. When a source must be delivered, the block raises a request toward a downstream presentation stage. The request carries the server, the source's external number (local index plus a base offset) and the priority.

The presentation stage talks back with three signals. A reject pulse returns a request it could not take. An end-of-interrupt pulse closes a delivered level interrupt. A resend pulse asks every source to replay anything still owed. Message sources retry through a rejected latch and a masked-pending latch. Level sources retry through an asserted flag and a sent flag. Requests wait as pending bits and leave one per cycle through a valid/ready handshake. The lowest local index goes first. A configuration write port updates one source at a time, and a combinational peek port reads back a source's stored settings.

Top module: `intsrc_ctl`

## Requirements
- R1: After reset, req_valid is 0, and every source peeks back priority 0xFF, saved priority 0xFF and server 0. All status flags are clear. Bit i of LEVEL_MAP (1 = level, 0 = message) fixes each kind and is not changed by reset.
- R2: A request for local source i shows req_num = BASE + i, together with that source's stored priority and server.
- R3: For a message source, a cycle with its src_in bit at 1 raises a request if the source is unmasked. If the source is masked (priority 0xFF), the cycle sets masked-pending and raises no request. A 0 on src_in has no effect.
- R4: A configuration write (cfg_we with cfg_idx) stores the server, priority and saved priority. If the target is a message source with masked-pending set and the new priority is not 0xFF, the write clears masked-pending and raises a request. Without masked-pending, the write raises no request.
- R5: For a level source, a change of src_in updates the asserted flag, and then a check runs. The check also runs on a configuration write to that source and on resend. It raises a request and sets sent only when the source is unmasked, asserted and not already sent. While sent is set, no further request is made.
- R6: A reject whose number matches a source sets rejected for a message source and clears sent for a level source.
- R7: An end-of-interrupt for a level source clears sent without itself raising a request. A later resend, or an input change, then re-requests if the check allows.
- R8: An end-of-interrupt for a message source has no effect. Reject or end-of-interrupt numbers outside BASE..BASE+NUM_SRC-1 have no effect.
- R9: On resend, every message source with rejected set clears it and re-requests if it is unmasked. Every level source runs the check of R5.
- R10: Pending requests leave at most one per cycle, lowest index first. A request stays valid until req_ready is 1 at a clock edge.
- R11: A source that stays masked never gains a new pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Level per level source, trigger per message source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Local index written |
| cfg_server | input | SRV_W | Server written |
| cfg_prio | input | 8 | Priority written (0xFF masks) |
| cfg_saved | input | 8 | Saved priority written |
| rej_valid | input | 1 | Reject pulse |
| rej_num | input | NUM_W | External number rejected |
| eoi_valid | input | 1 | End-of-interrupt pulse |
| eoi_num | input | NUM_W | External number ended |
| resend | input | 1 | Replay pulse for all sources |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Request taken at this edge |
| req_server | output | SRV_W | Destination server of the request |
| req_num | output | NUM_W | External source number of the request |
| req_prio | output | 8 | Priority of the request |
| peek_idx | input | IDX_W | Local index to read back |
| peek_server | output | SRV_W | Stored server of peek_idx |
| peek_prio | output | 8 | Stored priority of peek_idx |
| peek_saved | output | 8 | Stored saved priority of peek_idx |

## Verification
The bench builds six sources at base 32 and mixes the kinds, with local indices 2, 3 and 5 as level sources and the rest as message sources. This brings both retry disciplines, and a source count that is not a power of two, into one run. Rejects at 31 and 38 sit just outside the block's range. Because 32 and 37 sit at the ends of the range, the offset arithmetic is exercised in both directions. Stalling req_ready while two message sources fire together shows the lowest-first ordering and the hold behaviour.

// File: rtl/intsrc_pkg.sv
package intsrc_pkg;

  typedef logic [7:0] prio_t;

  localparam prio_t PRIO_MASKED = 8'hFF;

  // Per-source retry flags; level sources use asserted/sent, message
  // sources use rejected/mpend.
  typedef struct packed {
    logic asserted;
    logic sent;
    logic rejected;
    logic mpend;
  } stat_t;

  function automatic logic is_masked(prio_t p);
    return p == PRIO_MASKED;
  endfunction

endpackage

// File: rtl/intsrc_slot.sv
module intsrc_slot
  import intsrc_pkg::*;
#(
  parameter int SRV_W  = 4,
  parameter bit IS_LVL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl,
  input  logic             cfg_hit,
  input  logic [SRV_W-1:0] cfg_server,
  input  prio_t            cfg_prio,
  input  prio_t            cfg_saved,
  input  logic             rej_hit,
  input  logic             eoi_hit,
  input  logic             resend,
  input  logic             grant,
  output logic             pend,
  output logic             masked,
  output logic [SRV_W-1:0] server,
  output prio_t            prio,
  output prio_t            saved
);

  stat_t st_q, st_n;
  logic  pend_q, pend_n;
  prio_t prio_n;

  // Priority seen by this cycle's checks: a write in the same cycle wins.
  assign prio_n = cfg_hit ? cfg_prio : prio;

  generate
    if (IS_LVL) begin : g_lvl
      logic run_chk;
      always_comb begin
        st_n          = st_q;
        st_n.rejected = 1'b0;
        st_n.mpend    = 1'b0;
        pend_n        = pend_q & ~grant;
        run_chk       = cfg_hit | resend | (lvl != st_q.asserted);
        st_n.asserted = lvl;
        if (rej_hit || eoi_hit) st_n.sent = 1'b0;
        if (run_chk && !is_masked(prio_n) && st_n.asserted && !st_n.sent) begin
          st_n.sent = 1'b1;
          pend_n    = 1'b1;
        end
      end
    end else begin : g_msg
      always_comb begin
        st_n          = st_q;
        st_n.asserted = 1'b0;
        st_n.sent     = 1'b0;
        pend_n        = pend_q & ~grant;
        if (cfg_hit && st_q.mpend && !is_masked(prio_n)) begin
          st_n.mpend = 1'b0;
          pend_n     = 1'b1;
        end
        if (lvl) begin
          if (is_masked(prio_n)) st_n.mpend = 1'b1;
          else                   pend_n     = 1'b1;
        end
        if (rej_hit) st_n.rejected = 1'b1;
        if (resend && st_n.rejected) begin
          st_n.rejected = 1'b0;
          if (!is_masked(prio_n)) pend_n = 1'b1;
        end
      end
    end
  endgenerate

  // Configuration registers: clock enable is the write hit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio   <= PRIO_MASKED;
      saved  <= PRIO_MASKED;
      server <= '0;
    end else if (cfg_hit) begin
      prio   <= cfg_prio;
      saved  <= cfg_saved;
      server <= cfg_server;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      pend_q <= pend_n;
    end
  end

  assign pend   = pend_q;
  assign masked = is_masked(prio);

endmodule

// File: rtl/intsrc_pick.sv
module intsrc_pick #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     pend,
  output logic             any,
  output logic [IDX_W-1:0] sel
);

  // Scan from the top down so the lowest set index is the last to write.
  always_comb begin
    sel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) sel = IDX_W'(i);
    end
  end

  assign any = |pend;

endmodule

// File: rtl/intsrc_ctl.sv
module intsrc_ctl
  import intsrc_pkg::*;
#(
  parameter int             NUM_SRC   = 8,
  parameter int             SRV_W     = 4,
  parameter int             NUM_W     = 12,
  parameter int             BASE      = 16,
  parameter logic [NUM_SRC-1:0] LEVEL_MAP = 8'hF0,
  localparam int            IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [SRV_W-1:0]   cfg_server,
  input  logic [7:0]         cfg_prio,
  input  logic [7:0]         cfg_saved,
  input  logic               rej_valid,
  input  logic [NUM_W-1:0]   rej_num,
  input  logic               eoi_valid,
  input  logic [NUM_W-1:0]   eoi_num,
  input  logic               resend,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [SRV_W-1:0]   req_server,
  output logic [NUM_W-1:0]   req_num,
  output logic [7:0]         req_prio,
  input  logic [IDX_W-1:0]   peek_idx,
  output logic [SRV_W-1:0]   peek_server,
  output logic [7:0]         peek_prio,
  output logic [7:0]         peek_saved
);

  localparam logic [NUM_W-1:0] BASE_V = NUM_W'(BASE);

  logic [NUM_SRC-1:0] pend_v, mask_v, gnt_v;
  logic [SRV_W-1:0]   srv_a   [NUM_SRC];
  prio_t              prio_a  [NUM_SRC];
  prio_t              saved_a [NUM_SRC];
  logic [IDX_W-1:0]   pick_sel;
  logic               pick_any;

  intsrc_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
    .pend (pend_v),
    .any  (pick_any),
    .sel  (pick_sel)
  );

  assign req_valid = pick_any;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic cfg_hit, rej_hit, eoi_hit;
      assign cfg_hit  = cfg_we    && (cfg_idx == IDX_W'(i));
      assign rej_hit  = rej_valid && (rej_num == NUM_W'(BASE + i));
      assign eoi_hit  = eoi_valid && (eoi_num == NUM_W'(BASE + i));
      assign gnt_v[i] = pick_any && req_ready && (pick_sel == IDX_W'(i));

      intsrc_slot #(.SRV_W(SRV_W), .IS_LVL(LEVEL_MAP[i])) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl        (src_in[i]),
        .cfg_hit    (cfg_hit),
        .cfg_server (cfg_server),
        .cfg_prio   (cfg_prio),
        .cfg_saved  (cfg_saved),
        .rej_hit    (rej_hit),
        .eoi_hit    (eoi_hit),
        .resend     (resend),
        .grant      (gnt_v[i]),
        .pend       (pend_v[i]),
        .masked     (mask_v[i]),
        .server     (srv_a[i]),
        .prio       (prio_a[i]),
        .saved      (saved_a[i])
      );
    end
  endgenerate

  assign req_num    = BASE_V + NUM_W'(pick_sel);
  assign req_server = srv_a[pick_sel];
  assign req_prio   = prio_a[pick_sel];

  always_comb begin
    peek_server = '0;
    peek_prio   = '0;
    peek_saved  = '0;
    if (int'(peek_idx) < NUM_SRC) begin
      peek_server = srv_a[peek_idx];
      peek_prio   = prio_a[peek_idx];
      peek_saved  = saved_a[peek_idx];
    end
  end

endmodule

// File: rtl/intsrc_ctl_chk.sv
module intsrc_ctl_chk #(
  parameter int NUM_SRC = 8,
  parameter int NUM_W   = 12,
  parameter int BASE    = 16,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [NUM_W-1:0]   req_num,
  input logic [NUM_SRC-1:0] pend,
  input logic [NUM_SRC-1:0] masked,
  input logic [IDX_W-1:0]   sel
);

  logic [NUM_SRC-1:0] below_sel;
  always_comb begin
    below_sel = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (i < int'(sel)) below_sel[i] = 1'b1;
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid);

  // R2
  num_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (int'(req_num) >= BASE) && (int'(req_num) < BASE + NUM_SRC));

  // R10
  lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ((pend & below_sel) == '0) && pend[sel]);

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_m
      // R11
      masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(masked[i]) && masked[i] && !$past(pend[i]) |-> !pend[i]);
    end
  endgenerate

endmodule

bind intsrc_ctl intsrc_ctl_chk #(
  .NUM_SRC (NUM_SRC),
  .NUM_W   (NUM_W),
  .BASE    (BASE),
  .IDX_W   (IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_num   (req_num),
  .pend      (pend_v),
  .masked    (mask_v),
  .sel       (pick_sel)
);

// File: tb/test_intsrc_ctl.sv
`timescale 1ns/1ps
module test_intsrc_ctl;

  localparam int NS = 6;
  localparam int BS = 32;
  localparam logic [NS-1:0] LMAP = 6'b101100;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [NS-1:0] src_in;
  logic       cfg_we;
  logic [2:0] cfg_idx;
  logic [2:0] cfg_server;
  logic [7:0] cfg_prio, cfg_saved;
  logic       rej_valid, eoi_valid, resend;
  logic [7:0] rej_num, eoi_num;
  logic       req_valid, req_ready;
  logic [2:0] req_server;
  logic [7:0] req_num, req_prio;
  logic [2:0] peek_idx;
  logic [2:0] peek_server;
  logic [7:0] peek_prio, peek_saved;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;

  always #2.5 clk = ~clk;

  intsrc_ctl #(.NUM_SRC(NS), .SRV_W(3), .NUM_W(8), .BASE(BS), .LEVEL_MAP(LMAP)) i_intsrc_ctl (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_server(cfg_server),
    .cfg_prio(cfg_prio), .cfg_saved(cfg_saved),
    .rej_valid(rej_valid), .rej_num(rej_num),
    .eoi_valid(eoi_valid), .eoi_num(eoi_num), .resend(resend),
    .req_valid(req_valid), .req_ready(req_ready), .req_server(req_server),
    .req_num(req_num), .req_prio(req_prio),
    .peek_idx(peek_idx), .peek_server(peek_server),
    .peek_prio(peek_prio), .peek_saved(peek_saved)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_prio [NS];
  int m_srv  [NS];
  bit m_asrt [NS];
  bit m_sent [NS];
  bit m_rej  [NS];
  bit m_mp   [NS];
  bit m_pend [NS];

  function automatic int m_low();
    for (int i = 0; i < NS; i++) if (m_pend[i]) return i;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) begin
        m_prio[i] = 255; m_srv[i] = 0; m_asrt[i] = 0; m_sent[i] = 0;
        m_rej[i] = 0; m_mp[i] = 0; m_pend[i] = 0;
      end
    end else begin
      int g;
      g = req_ready ? m_low() : -1;
      for (int i = 0; i < NS; i++) begin
        bit np, ch, rh, eh, chg;
        np = m_pend[i] && (i != g);
        ch = cfg_we && (int'(cfg_idx) == i);
        rh = rej_valid && (int'(rej_num) == BS + i);
        eh = eoi_valid && (int'(eoi_num) == BS + i);
        if (ch) begin m_prio[i] = int'(cfg_prio); m_srv[i] = int'(cfg_server); end
        if (LMAP[i]) begin
          chg = (src_in[i] != m_asrt[i]);
          m_asrt[i] = src_in[i];
          if (rh || eh) m_sent[i] = 0;
          if ((ch || chg || resend) && m_prio[i] != 255 && m_asrt[i] && !m_sent[i]) begin
            m_sent[i] = 1; np = 1;
          end
        end else begin
          if (ch && m_mp[i] && m_prio[i] != 255) begin m_mp[i] = 0; np = 1; end
          if (src_in[i]) begin
            if (m_prio[i] == 255) m_mp[i] = 1; else np = 1;
          end
          if (rh) m_rej[i] = 1;
          if (resend && m_rej[i]) begin
            m_rej[i] = 0;
            if (m_prio[i] != 255) np = 1;
          end
        end
        m_pend[i] = np;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on && !done) begin
      int s;
      s = m_low();
      chk("R10 model valid", req_valid, s >= 0);
      if (s >= 0) begin
        chk("R2 model num", req_num, BS + s);
        chk("R2 model prio", req_prio, m_prio[s]);
        chk("R2 model server", req_server, m_srv[s]);
      end
    end
  end

  // ---------------- stimulus helpers (called just after a negedge) --------
  task automatic step(); @(negedge clk); endtask

  task automatic cfg(input int idx, input int srv, input int pr, input int sv);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_server = 3'(srv);
    cfg_prio = 8'(pr); cfg_saved = 8'(sv);
    step();
    cfg_we = 0;
  endtask

  task automatic trig(input logic [NS-1:0] bits);
    src_in = src_in | bits;
    step();
    src_in = src_in & ~bits;
  endtask

  task automatic rej(input int num);
    rej_valid = 1; rej_num = 8'(num); step(); rej_valid = 0;
  endtask

  task automatic eoi(input int num);
    eoi_valid = 1; eoi_num = 8'(num); step(); eoi_valid = 0;
  endtask

  task automatic rsnd();
    resend = 1; step(); resend = 0;
  endtask

  task automatic expect_req(input string tag, input bit v, input int num);
    chk({tag, " valid"}, req_valid, v);
    if (v) chk({tag, " num"}, req_num, num);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    rst_n = 0; src_in = '0; cfg_we = 0; cfg_idx = '0; cfg_server = '0;
    cfg_prio = '0; cfg_saved = '0; rej_valid = 0; rej_num = '0;
    eoi_valid = 0; eoi_num = '0; resend = 0; req_ready = 1; peek_idx = '0;
    repeat (3) step();
    rst_n = 1;
    cmp_on = 1;
    step();

    // R1 reset state
    chk("R1 req_valid", req_valid, 0);
    for (int i = 0; i < NS; i++) begin
      peek_idx = 3'(i); #0.1;
      chk("R1 prio", peek_prio, 8'hFF);
      chk("R1 saved", peek_saved, 8'hFF);
      chk("R1 server", peek_server, 0);
    end

    // R3 masked message trigger
    trig(6'b000001);
    expect_req("R3 masked trig", 0, 0);
    // R4 unmask releases masked-pending
    cfg(0, 2, 5, 6);
    expect_req("R4 release", 1, BS);
    chk("R4 prio", req_prio, 5);
    chk("R4 server", req_server, 2);
    peek_idx = 3'd0; #0.1;
    chk("R4 saved", peek_saved, 6);
    step();
    expect_req("R10 taken", 0, 0);

    // R3 unmasked trigger, zero ignored
    trig(6'b000001);
    expect_req("R3 trig", 1, BS);
    repeat (3) step();
    expect_req("R3 zero ignored", 0, 0);

    // R6 / R9 message reject and resend
    rej(BS);
    expect_req("R6 msg reject", 0, 0);
    rsnd();
    expect_req("R9 msg resend", 1, BS);
    step();
    rsnd();
    expect_req("R9 rejected cleared", 0, 0);

    // R9 masked resend drops, R4 no mpend no request
    rej(BS);
    cfg(0, 2, 255, 255);
    rsnd();
    expect_req("R9 masked resend", 0, 0);
    cfg(0, 2, 5, 5);
    expect_req("R4 no mpend", 0, 0);

    // R5 level source 2
    cfg(2, 1, 3, 3);
    expect_req("R5 not asserted", 0, 0);
    src_in[2] = 1'b1; step();
    expect_req("R5 level rise", 1, BS + 2);
    chk("R5 prio", req_prio, 3);
    chk("R5 server", req_server, 1);
    repeat (3) step();
    expect_req("R5 no repeat", 0, 0);
    rsnd();
    expect_req("R5 sent blocks", 0, 0);
    eoi(BS + 2);
    expect_req("R7 eoi no auto", 0, 0);
    rsnd();
    expect_req("R7 resend after eoi", 1, BS + 2);
    step();

    // R6 level reject
    rej(BS + 2);
    expect_req("R6 lvl reject", 0, 0);
    rsnd();
    expect_req("R6 lvl resend", 1, BS + 2);
    step();

    // R8 out of range and message eoi
    rej(BS + NS);
    rsnd();
    expect_req("R8 reject above range", 0, 0);
    rej(BS - 1);
    rsnd();
    expect_req("R8 reject below range", 0, 0);
    rej(BS);
    eoi(BS);
    rsnd();
    expect_req("R8 msg eoi no effect", 1, BS);
    step();

    // R5 level drop and re-rise
    src_in[2] = 1'b0; step();
    expect_req("R5 level drop", 0, 0);
    eoi(BS + 2);
    src_in[2] = 1'b1; step();
    expect_req("R5 re-rise", 1, BS + 2);
    step();

    // R10 serialization
    req_ready = 0;
    cfg(1, 4, 9, 9);
    trig(6'b000011);
    expect_req("R10 first", 1, BS);
    repeat (2) step();
    expect_req("R10 hold", 1, BS);
    req_ready = 1; step();
    expect_req("R10 second", 1, BS + 1);
    chk("R10 prio second", req_prio, 9);
    step();
    expect_req("R10 drained", 0, 0);

    // R2 top of range, level source 5
    cfg(5, 7, 0, 0);
    src_in[5] = 1'b1; step();
    expect_req("R2 top num", 1, BS + 5);
    chk("R2 top server", req_server, 7);
    step();

    // R4 masked-pending on source 4 released by config
    trig(6'b010000);
    expect_req("R3 masked src4", 0, 0);
    cfg(4, 3, 2, 2);
    expect_req("R4 release src4", 1, BS + 4);
    step();
    step();

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule